// File: doc/BRIEF.md
# Privileged Extended-Opcode ModRM Decoder

This block sits in the front end of a 186-class core and decodes the instruction group that shares a single primary opcode byte (0xFE by default) with the byte-wide increment and decrement. It takes instruction bytes one at a time over a valid/ready handshake. It splits the ModRM byte into its mode, extension and register/memory fields and collects any displacement and immediate bytes the form calls for. Once the last byte of an instruction has been taken, it presents a single-cycle decode result.

The extension values that the plain increment/decrement group leaves unused carry privileged operations. These are loads of the widened data, extra and stack segment registers, a return from privileged mode, a read of an 8-bit status register into a byte register, and a write of a control register from a 16-bit general register. These operations are accepted only while the privileged-mode input is high. Outside that mode, and for operand forms that make no sense, the block reports an illegal instruction instead of an operation.

The block produces decoded control only. It computes no effective address, makes no memory access and executes nothing. The length of every instruction depends on its ModRM byte alone, so an illegal instruction still consumes all of its operand bytes and the stream stays aligned.

Top module: `fe_ext_decoder`

## Requirements
- R1: While `rst_n` is low, `in_ready` and `dec_valid` are low. `in_ready` is high from the first clock edge after reset is released.
- R2: A first byte other than the group opcode (0xFE) produces a decode on its own. In that decode `dec_illegal`=1, `dec_op`=0 and every field output is zero.
- R3: For the ModRM byte, `dec_mode` reports bits 7:6, `dec_ext` reports bits 5:3 and `dec_rm` reports bits 2:0.
- R4: Extension 0 decodes as INC (`dec_op`=1) and extension 1 as DEC (`dec_op`=2). Both are legal in every mode and in either privilege state.
- R5: Extensions 2, 3 and 4 decode as loads of the extended DS (3), ES (4) and SS (5) segment registers. A register form (mode 3) of these is illegal.
- R6: Extension 5 decodes as the privileged return (`dec_op`=6) only with ModRM 0x28. Any other ModRM byte with extension 5 is illegal.
- R7: Extension 6 with mode 3 decodes as a status read (`dec_op`=7) into the byte register named by r/m. One immediate byte follows and is reported on `dec_imm`. Example: 0xFE 0xF3 0x0A reads index 0x0A into BL (r/m 3). Extension 6 with mode 0 to 2 is illegal.
- R8: Extension 7 with mode 3 and r/m 0 to 3 decodes as a control-register write (`dec_op`=8) from AX, CX, DX or BX respectively. Any other extension-7 form is illegal.
- R9: Extensions 2 to 7 are illegal (`dec_op`=0, `dec_illegal`=1) when `priv_mode` is low. Privilege is sampled in the cycle the ModRM byte is accepted.
- R10: Operand byte count follows the ModRM byte regardless of legality. Mode 1 takes one displacement byte. Mode 2, and mode 0 with r/m 6, take two displacement bytes, low byte first. Extension 6 adds one immediate byte after any displacement. `dec_disp_len` gives the displacement count.
- R11: A one-byte displacement is sign-extended to 16 bits on `dec_disp`. `dec_disp` is zero when there is no displacement, and `dec_imm` is zero when there is no immediate.
- R12: `dec_valid` is high for exactly the one cycle after the final byte of an instruction is accepted. The first byte of the next instruction may be accepted in that same cycle, and idle cycles (`in_valid` low) between bytes are allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| priv_mode | input | 1 | Privileged mode active |
| dec_valid | output | 1 | Decode result valid (one cycle) |
| dec_op | output | 4 | Operation code, 0 when illegal |
| dec_illegal | output | 1 | Illegal instruction |
| dec_mode | output | 2 | ModRM mode field |
| dec_ext | output | 3 | ModRM extension field |
| dec_rm | output | 3 | ModRM register/memory field |
| dec_disp_len | output | 2 | Displacement bytes consumed |
| dec_disp | output | 16 | Displacement, 8-bit form sign-extended |
| dec_imm | output | 8 | Immediate byte of the status read |

## Verification
Two things can happen in the same cycle. The decode result of one instruction can be presented while the first byte of the next instruction is being accepted, and a first byte that is not the group opcode can be flagged illegal in the very cycle after the previous result. The bench drives byte streams with no gaps, so each instruction ends and the next begins on consecutive edges, mixing foreign opcode bytes with full group instructions. It then compares every cycle's `dec_valid` and fields against a behavioural model that tracks which byte ended which instruction. It also flips `priv_mode` between the ModRM byte and the operand bytes, so that the privilege check and the operand collection overlap, and confirms that only the value at ModRM acceptance matters.

// File: rtl/fe_dec_pkg.sv
package fe_dec_pkg;

   typedef enum logic [3:0] {
      OP_NONE = 4'd0,
      OP_INC  = 4'd1,
      OP_DEC  = 4'd2,
      OP_LDDS = 4'd3,
      OP_LDES = 4'd4,
      OP_LDSS = 4'd5,
      OP_SRET = 4'd6,
      OP_STRD = 4'd7,
      OP_CRWR = 4'd8
   } op_t;

   typedef enum logic [2:0] {
      ST_OPC   = 3'd0,
      ST_MODRM = 3'd1,
      ST_D0    = 3'd2,
      ST_D1    = 3'd3,
      ST_IMM   = 3'd4
   } st_t;

   localparam logic [7:0] SRET_MODRM = 8'h28;

endpackage

// File: rtl/fe_modrm_class.sv
module fe_modrm_class
   import fe_dec_pkg::*;
(
   input  logic [7:0] modrm,
   input  logic       priv,
   output op_t        op,
   output logic       illegal
);

   logic [1:0] md;
   logic [2:0] ex;
   logic [2:0] rm;
   op_t        op_raw;
   logic       bad;

   assign md = modrm[7:6];
   assign ex = modrm[5:3];
   assign rm = modrm[2:0];

   always_comb begin
      op_raw = OP_NONE;
      bad    = 1'b0;
      case (ex)
         3'd0: op_raw = OP_INC;
         3'd1: op_raw = OP_DEC;
         3'd2: begin op_raw = OP_LDDS; bad = (md == 2'd3); end
         3'd3: begin op_raw = OP_LDES; bad = (md == 2'd3); end
         3'd4: begin op_raw = OP_LDSS; bad = (md == 2'd3); end
         3'd5: begin op_raw = OP_SRET; bad = (modrm != SRET_MODRM); end
         3'd6: begin op_raw = OP_STRD; bad = (md != 2'd3); end
         default: begin op_raw = OP_CRWR; bad = (md != 2'd3) || rm[2]; end
      endcase
      if ((ex >= 3'd2) && !priv) bad = 1'b1;
      illegal = bad;
      op      = bad ? OP_NONE : op_raw;
   end

endmodule

// File: rtl/fe_operand_len.sv
module fe_operand_len (
   input  logic [7:0] modrm,
   output logic [1:0] disp_len,
   output logic       has_imm
);

   always_comb begin
      case (modrm[7:6])
         2'd1:    disp_len = 2'd1;
         2'd2:    disp_len = 2'd2;
         2'd0:    disp_len = (modrm[2:0] == 3'd6) ? 2'd2 : 2'd0;
         default: disp_len = 2'd0;
      endcase
      has_imm = (modrm[5:3] == 3'd6);
   end

endmodule

// File: rtl/fe_disp_ext.sv
module fe_disp_ext #(
   parameter int BYTE_W      = 8,
   parameter int DISP_W      = 16,
   parameter bit SIGN_EXT_D8 = 1'b1
) (
   input  logic [BYTE_W-1:0] lo,
   input  logic [BYTE_W-1:0] hi,
   input  logic [1:0]        len,
   output logic [DISP_W-1:0] disp
);

   localparam int PAD_W = DISP_W - BYTE_W;

   logic [DISP_W-1:0] short_ext;

   generate
      if (SIGN_EXT_D8) begin : g_sext
         assign short_ext = {{PAD_W{lo[BYTE_W-1]}}, lo};
      end else begin : g_zext
         assign short_ext = {{PAD_W{1'b0}}, lo};
      end
   endgenerate

   always_comb begin
      case (len)
         2'd1:    disp = short_ext;
         2'd2:    disp = {hi, lo};
         default: disp = '0;
      endcase
   end

endmodule

// File: rtl/fe_ext_decoder.sv
module fe_ext_decoder
   import fe_dec_pkg::*;
#(
   parameter int               BYTE_W      = 8,
   parameter int               DISP_W      = 16,
   parameter logic [BYTE_W-1:0] OPC_BYTE   = 8'hFE,
   parameter bit               SIGN_EXT_D8 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   output logic              in_ready,
   input  logic              priv_mode,
   output logic              dec_valid,
   output logic [3:0]        dec_op,
   output logic              dec_illegal,
   output logic [1:0]        dec_mode,
   output logic [2:0]        dec_ext,
   output logic [2:0]        dec_rm,
   output logic [1:0]        dec_disp_len,
   output logic [DISP_W-1:0] dec_disp,
   output logic [BYTE_W-1:0] dec_imm
);

   localparam int LEN_W = 2;

   generate
      if (BYTE_W != 8) begin : g_bad_byte_w
         $error("fe_ext_decoder: BYTE_W must be 8");
      end
      if (DISP_W != 2 * BYTE_W) begin : g_bad_disp_w
         $error("fe_ext_decoder: DISP_W must be twice BYTE_W");
      end
   endgenerate

   st_t               st_q;
   logic [BYTE_W-1:0] modrm_q, lo_q, hi_q, imm_q;
   op_t               op_q;
   logic              ill_q;
   logic [LEN_W-1:0]  len_q;
   logic              imm_need_q;
   logic              vld_q;
   logic              rdy_q;
   logic              acc;

   op_t               cls_op;
   logic              cls_ill;
   logic [LEN_W-1:0]  cur_len;
   logic              cur_imm;

   assign acc = in_valid && rdy_q;

   fe_modrm_class u_class (
      .modrm   (in_byte),
      .priv    (priv_mode),
      .op      (cls_op),
      .illegal (cls_ill)
   );

   fe_operand_len u_len (
      .modrm    (in_byte),
      .disp_len (cur_len),
      .has_imm  (cur_imm)
   );

   fe_disp_ext #(
      .BYTE_W      (BYTE_W),
      .DISP_W      (DISP_W),
      .SIGN_EXT_D8 (SIGN_EXT_D8)
   ) u_disp (
      .lo   (lo_q),
      .hi   (hi_q),
      .len  (len_q),
      .disp (dec_disp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_OPC;
         modrm_q    <= '0;
         lo_q       <= '0;
         hi_q       <= '0;
         imm_q      <= '0;
         op_q       <= OP_NONE;
         ill_q      <= 1'b0;
         len_q      <= '0;
         imm_need_q <= 1'b0;
         vld_q      <= 1'b0;
         rdy_q      <= 1'b0;
      end else begin
         rdy_q <= 1'b1;
         vld_q <= 1'b0;
         if (acc) begin
            case (st_q)
               ST_OPC: begin
                  modrm_q    <= '0;
                  lo_q       <= '0;
                  hi_q       <= '0;
                  imm_q      <= '0;
                  len_q      <= '0;
                  imm_need_q <= 1'b0;
                  if (in_byte == OPC_BYTE) begin
                     st_q <= ST_MODRM;
                  end else begin
                     op_q  <= OP_NONE;
                     ill_q <= 1'b1;
                     vld_q <= 1'b1;
                  end
               end
               ST_MODRM: begin
                  modrm_q    <= in_byte;
                  op_q       <= cls_op;
                  ill_q      <= cls_ill;
                  len_q      <= cur_len;
                  imm_need_q <= cur_imm;
                  if (cur_len != 2'd0) begin
                     st_q <= ST_D0;
                  end else if (cur_imm) begin
                     st_q <= ST_IMM;
                  end else begin
                     st_q  <= ST_OPC;
                     vld_q <= 1'b1;
                  end
               end
               ST_D0: begin
                  lo_q <= in_byte;
                  if (len_q == 2'd2) begin
                     st_q <= ST_D1;
                  end else if (imm_need_q) begin
                     st_q <= ST_IMM;
                  end else begin
                     st_q  <= ST_OPC;
                     vld_q <= 1'b1;
                  end
               end
               ST_D1: begin
                  hi_q <= in_byte;
                  if (imm_need_q) begin
                     st_q <= ST_IMM;
                  end else begin
                     st_q  <= ST_OPC;
                     vld_q <= 1'b1;
                  end
               end
               ST_IMM: begin
                  imm_q <= in_byte;
                  st_q  <= ST_OPC;
                  vld_q <= 1'b1;
               end
               default: st_q <= ST_OPC;
            endcase
         end
      end
   end

   assign in_ready     = rdy_q;
   assign dec_valid    = vld_q;
   assign dec_op       = op_q;
   assign dec_illegal  = ill_q;
   assign dec_mode     = modrm_q[7:6];
   assign dec_ext      = modrm_q[5:3];
   assign dec_rm       = modrm_q[2:0];
   assign dec_disp_len = len_q;
   assign dec_imm      = imm_q;

   // R9
   priv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_MODRM && acc && !priv_mode && in_byte[5:3] >= 3'd2) |=> ill_q);

   // R2
   ill_no_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_illegal) |-> (dec_op == 4'd0));

   // R8
   crwr_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_op == 4'd8) |-> (dec_mode == 2'd3 && dec_rm <= 3'd3));

   // R10
   disp_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_illegal && dec_mode == 2'd2) |-> (dec_disp_len == 2'd2));

   // R12
   emit_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $past(acc));

   // R1
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |=> in_ready);

endmodule

// File: tb/fe_ext_decoder_tb.sv
module fe_ext_decoder_tb;

   typedef struct packed {
      logic [3:0]  op;
      logic        ill;
      logic [1:0]  mode;
      logic [2:0]  ext;
      logic [2:0]  rm;
      logic [1:0]  len;
      logic [15:0] disp;
      logic [7:0]  imm;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        priv_mode = 1'b0;
   logic        in_ready;
   logic        dec_valid;
   logic [3:0]  dec_op;
   logic        dec_illegal;
   logic [1:0]  dec_mode;
   logic [2:0]  dec_ext;
   logic [2:0]  dec_rm;
   logic [1:0]  dec_disp_len;
   logic [15:0] dec_disp;
   logic [7:0]  dec_imm;

   int nvec = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fe_ext_decoder u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_byte      (in_byte),
      .in_ready     (in_ready),
      .priv_mode    (priv_mode),
      .dec_valid    (dec_valid),
      .dec_op       (dec_op),
      .dec_illegal  (dec_illegal),
      .dec_mode     (dec_mode),
      .dec_ext      (dec_ext),
      .dec_rm       (dec_rm),
      .dec_disp_len (dec_disp_len),
      .dec_disp     (dec_disp),
      .dec_imm      (dec_imm)
   );

   function automatic exp_t model(input logic [7:0] opc, input logic [7:0] mrm,
                                  input logic [7:0] d0, input logic [7:0] d1,
                                  input logic [7:0] im, input bit p);
      exp_t e;
      int   x;
      e = '0;
      if (opc != 8'hFE) begin
         e.ill = 1'b1;
         return e;
      end
      e.mode = mrm[7:6];
      e.ext  = mrm[5:3];
      e.rm   = mrm[2:0];
      if (e.mode == 2'd1) e.len = 2'd1;
      else if (e.mode == 2'd2) e.len = 2'd2;
      else if (e.mode == 2'd0 && e.rm == 3'd6) e.len = 2'd2;
      if (e.len == 2'd1) e.disp = {{8{d0[7]}}, d0};
      else if (e.len == 2'd2) e.disp = {d1, d0};
      if (e.ext == 3'd6) e.imm = im;
      x = int'(e.ext);
      if (x == 0) e.op = 4'd1;
      else if (x == 1) e.op = 4'd2;
      else if (x <= 4) begin
         if (e.mode == 2'd3) e.ill = 1'b1; else e.op = 4'(x + 1);
      end else if (x == 5) begin
         if (mrm == 8'h28) e.op = 4'd6; else e.ill = 1'b1;
      end else if (x == 6) begin
         if (e.mode == 2'd3) e.op = 4'd7; else e.ill = 1'b1;
      end else begin
         if (e.mode == 2'd3 && e.rm < 3'd4) e.op = 4'd8; else e.ill = 1'b1;
      end
      if (x >= 2 && !p) e.ill = 1'b1;
      if (e.ill) e.op = 4'd0;
      return e;
   endfunction

   task automatic compare(input bit expv, input exp_t e, input string tag);
      exp_t got;
      nvec++;
      got = '{dec_op, dec_illegal, dec_mode, dec_ext, dec_rm, dec_disp_len, dec_disp, dec_imm};
      if (!expv) begin
         if (dec_valid !== 1'b0) begin
            nfail++;
            $display("FAIL %s: dec_valid=%0b expected 0", tag, dec_valid);
         end
      end else if (dec_valid !== 1'b1 || got !== e) begin
         nfail++;
         $display("FAIL %s: valid=%0b got=%h expected valid=1 %h", tag, dec_valid, got, e);
      end
   endtask

   task automatic drive(input logic [7:0] b, input bit p, input bit last,
                        input exp_t e, input string tag);
      in_valid  = 1'b1;
      in_byte   = b;
      priv_mode = p;
      @(negedge clk);
      compare(last, e, tag);
   endtask

   task automatic idle(input string tag);
      in_valid = 1'b0;
      @(negedge clk);
      compare(1'b0, '0, tag);
   endtask

   // p_m: privilege while ModRM byte is offered; p_o: on all other bytes
   task automatic instr(input logic [7:0] opc, input logic [7:0] mrm,
                        input logic [7:0] d0, input logic [7:0] d1,
                        input logic [7:0] im, input bit p_m, input bit p_o,
                        input bit gap, input string tag);
      exp_t e;
      logic [7:0] b [5];
      int n;
      e = model(opc, mrm, d0, d1, im, p_m);
      b[0] = opc;
      n = 1;
      if (opc == 8'hFE) begin
         b[1] = mrm;
         n = 2;
         if (e.len >= 2'd1) begin b[n] = d0; n++; end
         if (e.len == 2'd2) begin b[n] = d1; n++; end
         if (mrm[5:3] == 3'd6) begin b[n] = im; n++; end
      end
      for (int i = 0; i < n; i++) begin
         if (gap && i == 1) idle({tag, " gap"});
         drive(b[i], (i == 1) ? p_m : p_o, (i == n - 1), e, tag);
      end
   endtask

   initial begin
      // R1: reset state
      in_valid = 1'b1;
      in_byte  = 8'hFE;
      repeat (3) begin
         @(negedge clk);
         nvec++;
         if (in_ready !== 1'b0 || dec_valid !== 1'b0) begin
            nfail++;
            $display("FAIL R1: in_ready=%0b dec_valid=%0b expected 0 0", in_ready, dec_valid);
         end
      end
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      nvec++;
      if (in_ready !== 1'b1 || dec_valid !== 1'b0) begin
         nfail++;
         $display("FAIL R1: in_ready=%0b dec_valid=%0b expected 1 0", in_ready, dec_valid);
      end

      instr(8'h90, 8'h00, 8'h00, 8'h00, 8'h00, 1, 1, 0, "R2 foreign opcode");
      instr(8'hFE, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0, "R4 R3 INC [bx+si]");
      instr(8'hFE, 8'hC8, 8'h00, 8'h00, 8'h00, 0, 0, 0, "R4 R3 DEC AL");
      instr(8'hFE, 8'h40, 8'h80, 8'h00, 8'h00, 0, 0, 0, "R11 R10 INC disp8 neg");
      instr(8'hFE, 8'h47, 8'h7F, 8'h00, 8'h00, 0, 0, 0, "R11 disp8 pos");
      instr(8'hFE, 8'h8B, 8'h34, 8'h12, 8'h00, 0, 0, 0, "R10 DEC disp16");
      instr(8'hFE, 8'h06, 8'h78, 8'h56, 8'h00, 0, 0, 0, "R10 INC direct");
      instr(8'hFE, 8'h94, 8'h34, 8'h12, 8'h00, 1, 1, 0, "R5 load DS");
      instr(8'hFE, 8'h1E, 8'hCD, 8'hAB, 8'h00, 1, 1, 0, "R5 load ES direct");
      instr(8'hFE, 8'h62, 8'h05, 8'h00, 8'h00, 1, 1, 0, "R5 load SS");
      instr(8'hFE, 8'hD0, 8'h00, 8'h00, 8'h00, 1, 1, 0, "R5 reg form illegal");
      instr(8'hFE, 8'h28, 8'h00, 8'h00, 8'h00, 1, 1, 0, "R6 return");
      instr(8'hFE, 8'h2B, 8'h00, 8'h00, 8'h00, 1, 1, 0, "R6 noncanonical");
      instr(8'hFE, 8'h68, 8'h11, 8'h00, 8'h00, 1, 1, 0, "R6 R10 illegal consumes disp");
      instr(8'hFE, 8'hF3, 8'h00, 8'h00, 8'h0A, 1, 1, 0, "R7 status read BL");
      instr(8'hFE, 8'hF0, 8'h00, 8'h00, 8'hFF, 1, 1, 0, "R7 status read AL");
      instr(8'hFE, 8'h30, 8'h00, 8'h00, 8'h22, 1, 1, 0, "R7 memory form illegal");
      instr(8'hFE, 8'hB6, 8'h01, 8'h02, 8'h33, 1, 1, 0, "R7 R10 disp then imm");
      for (int r = 0; r < 8; r++)
         instr(8'hFE, 8'hF8 | 8'(r), 8'h00, 8'h00, 8'h00, 1, 1, 0, "R8 ctrl write rm");
      instr(8'hFE, 8'h38, 8'h00, 8'h00, 8'h00, 1, 1, 0, "R8 mode0 illegal");
      instr(8'hFE, 8'h28, 8'h00, 8'h00, 8'h00, 0, 0, 0, "R9 return unpriv");
      instr(8'hFE, 8'hF3, 8'h00, 8'h00, 8'h0A, 0, 0, 0, "R9 status unpriv");
      instr(8'hFE, 8'hF8, 8'h00, 8'h00, 8'h00, 0, 0, 0, "R9 ctrl unpriv");
      instr(8'hFE, 8'h94, 8'h34, 8'h12, 8'h00, 1, 0, 0, "R9 priv drops after ModRM");
      instr(8'hFE, 8'h94, 8'h34, 8'h12, 8'h00, 0, 1, 0, "R9 priv only around ModRM");
      instr(8'hFE, 8'h8C, 8'hEF, 8'hBE, 8'h00, 1, 1, 1, "R12 gap in stream");
      idle("R12 idle");
      instr(8'h0F, 8'h00, 8'h00, 8'h00, 8'h00, 1, 1, 0, "R12 R2 back-to-back a");
      instr(8'hCC, 8'h00, 8'h00, 8'h00, 8'h00, 1, 1, 0, "R12 R2 back-to-back b");
      instr(8'hFE, 8'h28, 8'h00, 8'h00, 8'h00, 1, 1, 0, "R12 after foreign");
      idle("R12 trailing idle");
      idle("R12 trailing idle");

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nfail++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

endmodule